// File: doc/BRIEF.md
# 16-bit Execute Unit with Flags

This block is the execute stage of a 16-bit processor with sixteen general registers. Each cycle in which `in_valid` is high, it takes an instruction word, three register read values (the registers named by the destination, A and B fields), the current program counter and the status register. It decodes the word, runs the ALU, shift, immediate or compare operation, and works out the new N, Z and C flags. It also resolves conditional branches and calls into a taken flag and a target address. All results are registered and appear one cycle later, qualified by `out_valid`.

Loads, stores, port transfers, register swaps and the exception-control sub-operations belong to other stages. This unit decodes them, but they produce no write-back, no flag change and no branch here. An undefined branch condition raises `illegal` and suppresses every other effect.

Top module: `exu_core`

## Requirements
- R1: After reset, and in any cycle following one with `in_valid` low, `out_valid`, `wb_en`, `br_taken` and `illegal` are 0. Results for an instruction appear on the first rising edge after it is presented.
- R2: The instruction word is split as destination [15:12], A [11:8], B [7:4] and opcode [3:0]. The opcodes are: 0 load-immediate, 1 load-immediate-high, 2..5 memory, 6 add, 7 add-with-carry, 8 and, 9 or, 10 xor, 11 shift left, 12 logical shift right, 13 arithmetic shift right, 14 branch, 15 extended. Opcode 15 takes B as a sub-opcode: 0 move, 1 negate, 2 not, 3 compare, 4 call, 5 swap, 6..9 port transfers, 10 add-immediate, 11 and-immediate, 12 or-immediate, 13 shift-immediate, 14 compare-immediate, 15 system. `wb_idx` is the destination field.
- R3: The status flags are Z at bit 2, C at bit 3 and N at bit 4. All other bits of `sr_out` equal `sr_in`. Arithmetic operations (add, add-with-carry, negate, compares, shifts, add-immediate) set Z when the low 16 result bits are zero, N from result bit 15, and C from result bit 16. For subtraction, C is the borrow.
- R4: Bitwise operations (and, or, xor, not, and-immediate, or-immediate) update only N and Z and leave C as it was.
- R5: Add-with-carry adds the incoming C flag. Compare computes destination minus A and updates the flags with `wb_en` low.
- R6: Add-, and- and or-immediate take the A field as a 4-bit value sign-extended from bit 3, where 0 stands for +8. Compare-immediate sign-extends the A field with no such substitution, and does not write back.
- R7: Load-immediate writes the sign-extended 8-bit value {A,B}. Load-immediate-high writes {A,B} into bits 15:8 and keeps bits 7:0 of the destination value. Neither changes the flags.
- R8: Register shifts move A by the full 16-bit value of B. A left shift puts result bit 16 into C. Right shifts put the last bit shifted out into C, and the arithmetic form fills with the sign bit. A count of 0 leaves the value unchanged and clears C. Counts above 16 give all fill bits.
- R9: Shift-immediate shifts the destination value. A-field bit 3 set selects a logical right shift and clear selects a left shift. Bits 2:0 give the count, with 0 meaning 8.
- R10: Branch conditions sit in the destination field: 0 always, 1 never, 2 Z set, 3 Z clear, 4 N set, 5 N clear, 6 C set, 7 C clear, 8 Z and C both clear, 9 Z or C set. A taken branch targets `pc` plus the sign-extended {A,B} times two. Branches do not change the flags.
- R11: Branch condition codes 10..15 raise `illegal`, with no write-back, no branch and `sr_out` equal to `sr_in`.
- R12: Call writes `pc` minus 2 to the destination and branches to the value of register A, without touching the flags.
- R13: Memory opcodes 2..5 and sub-opcodes 5..9 and 15 produce no write-back, no branch, no illegal flag and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the following instruction |
| rd_dst | input | 16 | Value of the register named by the destination field |
| rd_a | input | 16 | Value of the register named by field A |
| rd_b | input | 16 | Value of the register named by field B |
| sr_in | input | 16 | Current status register |
| out_valid | output | 1 | Registered results are valid |
| wb_en | output | 1 | Write `wb_data` to register `wb_idx` |
| wb_idx | output | 4 | Destination register index |
| wb_data | output | 16 | Write-back value |
| sr_out | output | 16 | Status register after the instruction |
| br_taken | output | 1 | Branch or call taken |
| br_target | output | 16 | New program counter when taken |
| illegal | output | 1 | Undefined branch condition |

## Verification
The embedded properties take for granted that `in_valid` is held low through reset and that every input is a known value whenever `in_valid` is high. This is because they compare the registered results against the instruction and status word captured on the same edge. The bench drives every input from time zero and changes them only on falling edges. It presents each instruction for exactly one cycle with fully specified operands, and it pulls `in_valid` low before its idle and reset checks, so the properties never see an undefined word.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int unsigned DW    = 16;          // datapath width
  localparam int unsigned FW    = 4;           // instruction field width
  localparam int unsigned HALF  = DW / 2;
  localparam int unsigned CODEW = DW - FW;     // bits below the destination field
  localparam int unsigned SR_Z  = 2;
  localparam int unsigned SR_C  = 3;
  localparam int unsigned SR_N  = 4;

  typedef enum logic [FW-1:0] {
    OPC_LDI = 4'd0, OPC_LDIH = 4'd1, OPC_LDB = 4'd2, OPC_LDW = 4'd3,
    OPC_STB = 4'd4, OPC_STW = 4'd5, OPC_ADD = 4'd6, OPC_ADC = 4'd7,
    OPC_AND = 4'd8, OPC_OR = 4'd9, OPC_XOR = 4'd10, OPC_SHL = 4'd11,
    OPC_SHR = 4'd12, OPC_SAR = 4'd13, OPC_BRANCH = 4'd14, OPC_EXT = 4'd15
  } opc_e;

  typedef enum logic [FW-1:0] {
    SUB_MOV = 4'd0, SUB_NEG = 4'd1, SUB_NOT = 4'd2, SUB_CMP = 4'd3,
    SUB_CALL = 4'd4, SUB_SWAP = 4'd5, SUB_PIN = 4'd6, SUB_POUT = 4'd7,
    SUB_PINI = 4'd8, SUB_POUTI = 4'd9, SUB_ADDI = 4'd10, SUB_ANDI = 4'd11,
    SUB_ORI = 4'd12, SUB_SHI = 4'd13, SUB_CMPI = 4'd14, SUB_SYS = 4'd15
  } sub_e;

  typedef enum logic [3:0] {
    ALU_PASSX, ALU_PASSY, ALU_MERGE, ALU_ADD, ALU_ADC, ALU_SUB, ALU_AND,
    ALU_OR, ALU_XOR, ALU_NOT, ALU_SHL, ALU_SHR, ALU_SAR
  } alu_op_e;

  typedef enum logic [1:0] {X_DST, X_A, X_ZERO, X_PC} xsel_e;
  typedef enum logic [1:0] {Y_A, Y_B, Y_IMM} ysel_e;
  typedef enum logic [1:0] {FL_NONE, FL_ARITH, FL_LOGIC} flag_e;

  typedef struct packed {
    alu_op_e         op;
    xsel_e           xs;
    ysel_e           ys;
    logic [DW-1:0]   imm;
    logic            wb;
    flag_e           fl;
    logic            br;
    logic            call;
  } ctl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [CODEW-1:0] code,
  output ctl_t             ctl
);
  logic [FW-1:0] fa, fb;
  opc_e          opc;
  sub_e          sub;
  logic [DW-1:0] imm_short;   // 4-bit, zero means +8
  logic [DW-1:0] imm_plain;   // 4-bit, plain sign extension
  logic [DW-1:0] imm_byte;    // 8-bit sign extension
  logic [DW-1:0] shi_count;

  always_comb begin
    fa  = code[CODEW-1 -: FW];
    fb  = code[2*FW-1 -: FW];
    opc = opc_e'(code[FW-1:0]);
    sub = sub_e'(fb);
    imm_plain = {{(DW-FW){fa[FW-1]}}, fa};
    imm_short = (fa == '0) ? DW'(8) : imm_plain;
    imm_byte  = {{(DW-2*FW){fa[FW-1]}}, fa, fb};
    shi_count = (fa[FW-2:0] == '0) ? DW'(8) : DW'(fa[FW-2:0]);
  end

  always_comb begin
    ctl = '{op: ALU_PASSX, xs: X_A, ys: Y_B, imm: '0, wb: 1'b0,
            fl: FL_NONE, br: 1'b0, call: 1'b0};
    case (opc)
      OPC_LDI:  begin ctl.op = ALU_PASSY; ctl.ys = Y_IMM; ctl.imm = imm_byte; ctl.wb = 1'b1; end
      OPC_LDIH: begin
        ctl.op = ALU_MERGE; ctl.xs = X_DST; ctl.ys = Y_IMM;
        ctl.imm = {fa, fb, {HALF{1'b0}}}; ctl.wb = 1'b1;
      end
      OPC_ADD:  begin ctl.op = ALU_ADD; ctl.wb = 1'b1; ctl.fl = FL_ARITH; end
      OPC_ADC:  begin ctl.op = ALU_ADC; ctl.wb = 1'b1; ctl.fl = FL_ARITH; end
      OPC_AND:  begin ctl.op = ALU_AND; ctl.wb = 1'b1; ctl.fl = FL_LOGIC; end
      OPC_OR:   begin ctl.op = ALU_OR;  ctl.wb = 1'b1; ctl.fl = FL_LOGIC; end
      OPC_XOR:  begin ctl.op = ALU_XOR; ctl.wb = 1'b1; ctl.fl = FL_LOGIC; end
      OPC_SHL:  begin ctl.op = ALU_SHL; ctl.wb = 1'b1; ctl.fl = FL_ARITH; end
      OPC_SHR:  begin ctl.op = ALU_SHR; ctl.wb = 1'b1; ctl.fl = FL_ARITH; end
      OPC_SAR:  begin ctl.op = ALU_SAR; ctl.wb = 1'b1; ctl.fl = FL_ARITH; end
      OPC_BRANCH: ctl.br = 1'b1;
      OPC_EXT: begin
        case (sub)
          SUB_MOV: begin ctl.op = ALU_PASSX; ctl.wb = 1'b1; end
          SUB_NEG: begin
            ctl.op = ALU_SUB; ctl.xs = X_ZERO; ctl.ys = Y_A;
            ctl.wb = 1'b1; ctl.fl = FL_ARITH;
          end
          SUB_NOT: begin ctl.op = ALU_NOT; ctl.wb = 1'b1; ctl.fl = FL_LOGIC; end
          SUB_CMP: begin
            ctl.op = ALU_SUB; ctl.xs = X_DST; ctl.ys = Y_A; ctl.fl = FL_ARITH;
          end
          SUB_CALL: begin
            ctl.op = ALU_SUB; ctl.xs = X_PC; ctl.ys = Y_IMM; ctl.imm = DW'(2);
            ctl.wb = 1'b1; ctl.call = 1'b1;
          end
          SUB_ADDI: begin
            ctl.op = ALU_ADD; ctl.xs = X_DST; ctl.ys = Y_IMM; ctl.imm = imm_short;
            ctl.wb = 1'b1; ctl.fl = FL_ARITH;
          end
          SUB_ANDI: begin
            ctl.op = ALU_AND; ctl.xs = X_DST; ctl.ys = Y_IMM; ctl.imm = imm_short;
            ctl.wb = 1'b1; ctl.fl = FL_LOGIC;
          end
          SUB_ORI: begin
            ctl.op = ALU_OR; ctl.xs = X_DST; ctl.ys = Y_IMM; ctl.imm = imm_short;
            ctl.wb = 1'b1; ctl.fl = FL_LOGIC;
          end
          SUB_SHI: begin
            ctl.op = fa[FW-1] ? ALU_SHR : ALU_SHL; ctl.xs = X_DST; ctl.ys = Y_IMM;
            ctl.imm = shi_count; ctl.wb = 1'b1; ctl.fl = FL_ARITH;
          end
          SUB_CMPI: begin
            ctl.op = ALU_SUB; ctl.xs = X_DST; ctl.ys = Y_IMM; ctl.imm = imm_plain;
            ctl.fl = FL_ARITH;
          end
          default: ;  // swap, port transfers, system: handled in other stages
        endcase
      end
      default: ;      // memory opcodes: handled in the memory stage
    endcase
  end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
(
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int unsigned WW   = 2 * DW;
  localparam int unsigned CNTW = $clog2(WW);
  localparam logic [CNTW-1:0] NMAX = CNTW'(WW - 1);

  logic [CNTW-1:0]        n;
  logic [WW-1:0]          lwide;
  logic signed [WW-1:0]   rwide;
  logic [DW-1:0]          fill;

  always_comb begin
    n     = (amt > DW'(NMAX)) ? NMAX : amt[CNTW-1:0];
    fill  = (arith && val[DW-1]) ? '1 : '0;
    lwide = {{DW{1'b0}}, val} << n;
    rwide = '0;
    if (left) begin
      res  = lwide[DW-1:0];
      cout = lwide[DW];
    end else if (n == '0) begin
      res  = val;
      cout = 1'b0;
    end else begin
      // shift one short so bit 0 holds the last bit moved out
      rwide = $signed({fill, val}) >>> (n - CNTW'(1));
      res   = rwide[DW:1];
      cout  = rwide[0];
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0]   sum;
  logic [DW:0]   diff;
  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic          sh_left;
  logic          sh_arith;

  assign sh_left  = (op == ALU_SHL);
  assign sh_arith = (op == ALU_SAR);

  exu_shift u_shift (
    .val   (x),
    .amt   (y),
    .left  (sh_left),
    .arith (sh_arith),
    .res   (sh_res),
    .cout  (sh_cout)
  );

  always_comb begin
    sum  = {1'b0, x} + {1'b0, y} + (DW+1)'((op == ALU_ADC) && cin);
    diff = {1'b0, x} - {1'b0, y};
    res  = x;
    cout = 1'b0;
    case (op)
      ALU_PASSX: res = x;
      ALU_PASSY: res = y;
      ALU_MERGE: res = {y[DW-1:HALF], x[HALF-1:0]};
      ALU_ADD, ALU_ADC: begin res = sum[DW-1:0];  cout = sum[DW];  end
      ALU_SUB:          begin res = diff[DW-1:0]; cout = diff[DW]; end
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      ALU_XOR: res = x ^ y;
      ALU_NOT: res = ~x;
      ALU_SHL, ALU_SHR, ALU_SAR: begin res = sh_res; cout = sh_cout; end
      default: res = x;
    endcase
  end
endmodule

// File: rtl/exu_branch.sv
module exu_branch
  import exu_pkg::*;
(
  input  logic [FW-1:0]   cond,
  input  logic [2*FW-1:0] disp,
  input  logic [DW-1:0]   pc,
  input  logic            fz,
  input  logic            fc,
  input  logic            fn,
  output logic            taken,
  output logic            bad,
  output logic [DW-1:0]   target
);
  always_comb begin
    bad = 1'b0;
    case (cond)
      4'd0: taken = 1'b1;
      4'd1: taken = 1'b0;
      4'd2: taken = fz;
      4'd3: taken = !fz;
      4'd4: taken = fn;
      4'd5: taken = !fn;
      4'd6: taken = fc;
      4'd7: taken = !fc;
      4'd8: taken = !fz && !fc;
      4'd9: taken = fz || fc;
      default: begin taken = 1'b0; bad = 1'b1; end
    endcase
    target = pc + {{(DW-2*FW-1){disp[2*FW-1]}}, disp, 1'b0};
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   instr,
  input  logic [15:0]   pc,
  input  logic [15:0]   rd_dst,
  input  logic [15:0]   rd_a,
  input  logic [15:0]   rd_b,
  input  logic [15:0]   sr_in,
  output logic          out_valid,
  output logic          wb_en,
  output logic [3:0]    wb_idx,
  output logic [15:0]   wb_data,
  output logic [15:0]   sr_out,
  output logic          br_taken,
  output logic [15:0]   br_target,
  output logic          illegal
);
  localparam logic [DW-1:0] FLAG_MASK = DW'((1 << SR_Z) | (1 << SR_C) | (1 << SR_N));

  ctl_t          ctl;
  logic [DW-1:0] opx, opy, alu_res;
  logic          alu_cout;
  logic          br_ok, br_bad;
  logic [DW-1:0] br_addr;

  // next-state values
  logic          wb_n, br_n, ill_n;
  logic [DW-1:0] sr_n, tgt_n;

  // captured instruction context, used by the checks below
  logic [DW-1:0] q_instr, q_sr;

  exu_decode u_decode (
    .code (instr[CODEW-1:0]),
    .ctl  (ctl)
  );

  always_comb begin
    case (ctl.xs)
      X_DST:   opx = rd_dst;
      X_A:     opx = rd_a;
      X_PC:    opx = pc;
      default: opx = '0;
    endcase
    case (ctl.ys)
      Y_A:     opy = rd_a;
      Y_B:     opy = rd_b;
      default: opy = ctl.imm;
    endcase
  end

  exu_alu u_alu (
    .op   (ctl.op),
    .x    (opx),
    .y    (opy),
    .cin  (sr_in[SR_C]),
    .res  (alu_res),
    .cout (alu_cout)
  );

  exu_branch u_branch (
    .cond   (instr[DW-1 -: FW]),
    .disp   (instr[CODEW-1 -: 2*FW]),
    .pc     (pc),
    .fz     (sr_in[SR_Z]),
    .fc     (sr_in[SR_C]),
    .fn     (sr_in[SR_N]),
    .taken  (br_ok),
    .bad    (br_bad),
    .target (br_addr)
  );

  always_comb begin
    sr_n = sr_in;
    if (ctl.fl != FL_NONE) begin
      sr_n[SR_Z] = (alu_res == '0);
      sr_n[SR_N] = alu_res[DW-1];
      if (ctl.fl == FL_ARITH) sr_n[SR_C] = alu_cout;
    end
    wb_n  = ctl.wb;
    ill_n = ctl.br && br_bad;
    br_n  = (ctl.br && br_ok) || ctl.call;
    tgt_n = ctl.call ? rd_a : br_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      br_taken  <= 1'b0;
      illegal   <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      sr_out    <= '0;
      br_target <= '0;
      q_instr   <= '0;
      q_sr      <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && wb_n;
      br_taken  <= in_valid && br_n;
      illegal   <= in_valid && ill_n;
      if (in_valid) begin
        wb_idx    <= instr[DW-1 -: FW];
        wb_data   <= alu_res;
        sr_out    <= sr_n;
        br_target <= tgt_n;
        q_instr   <= instr;
        q_sr      <= sr_in;
      end
    end
  end

  opc_e q_opc;
  sub_e q_sub;
  assign q_opc = opc_e'(q_instr[FW-1:0]);
  assign q_sub = sub_e'(q_instr[2*FW-1 -: FW]);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !br_taken && !illegal)); // R1
  AST_SR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((sr_out & ~FLAG_MASK) == (q_sr & ~FLAG_MASK))); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wb_en && (q_opc inside {OPC_ADD, OPC_ADC, OPC_AND, OPC_OR,
      OPC_XOR, OPC_SHL, OPC_SHR, OPC_SAR})) |-> (sr_out[SR_Z] == (wb_data == '0))); // R3
  AST_BITWISE_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (q_opc inside {OPC_AND, OPC_OR, OPC_XOR})) |-> (sr_out[SR_C] == q_sr[SR_C])); // R4
  AST_COMPARE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_opc == OPC_EXT && (q_sub inside {SUB_CMP, SUB_CMPI})) |-> !wb_en); // R5
  AST_NEVER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_opc == OPC_BRANCH && q_instr[DW-1 -: FW] == 4'd1) |-> !br_taken); // R10
  AST_BRANCH_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_opc == OPC_BRANCH) |-> (sr_out == q_sr && !wb_en)); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && !br_taken && sr_out == q_sr)); // R11
  AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_opc == OPC_EXT && q_sub == SUB_CALL) |-> (br_taken && wb_en)); // R12
endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;
  typedef struct packed {
    logic [15:0] instr, dv, av, bv, sr, pc;
    logic        wbe;
    logic [15:0] wbd, sro;
    logic        br;
    logic [15:0] tgt;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VECS [NV] = '{
    '{16'h1236,16'h0000,16'hFFFF,16'h0001,16'h8001,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd3}, // R3 add carry out
    '{16'h1236,16'h0000,16'h7FFF,16'h0001,16'h800D,16'h1000,1'b1,16'h8000,16'h8011,1'b0,16'h0000,1'b0,4'd3}, // R3 add negative
    '{16'h1237,16'h0000,16'h0001,16'h0001,16'h8009,16'h1000,1'b1,16'h0003,16'h8001,1'b0,16'h0000,1'b0,4'd5}, // R5 adc with C
    '{16'h1237,16'h0000,16'hFFFF,16'h0000,16'h8001,16'h1000,1'b1,16'hFFFF,16'h8011,1'b0,16'h0000,1'b0,4'd5}, // R5 adc without C
    '{16'h1238,16'h0000,16'hF0F0,16'h0F0F,16'h8009,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd4}, // R4 and keeps C
    '{16'h123A,16'h0000,16'h8000,16'h0001,16'h8005,16'h1000,1'b1,16'h8001,16'h8011,1'b0,16'h0000,1'b0,4'd4}, // R4 xor
    '{16'h1239,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd4}, // R4 or zero
    '{16'h123F,16'h0005,16'h0007,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8019,1'b0,16'h0000,1'b0,4'd5}, // R5 cmp borrow
    '{16'h123F,16'h1234,16'h1234,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd5}, // R5 cmp equal
    '{16'h10AF,16'h0010,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'h0018,16'h8001,1'b0,16'h0000,1'b0,4'd6}, // R6 addi 0 is +8
    '{16'h1FAF,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'hFFFF,16'h8011,1'b0,16'h0000,1'b0,4'd6}, // R6 addi -1
    '{16'h1FAF,16'h0001,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd6}, // R6 addi wrap
    '{16'h10BF,16'h00FF,16'h0000,16'h0000,16'h8009,16'h1000,1'b1,16'h0008,16'h8009,1'b0,16'h0000,1'b0,4'd6}, // R6 andi +8
    '{16'h19CF,16'h0006,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'hFFFF,16'h8011,1'b0,16'h0000,1'b0,4'd6}, // R6 ori -7
    '{16'h10EF,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd6}, // R6 cmpi 0 is 0
    '{16'h1FEF,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8009,1'b0,16'h0000,1'b0,4'd6}, // R6 cmpi -1
    '{16'h1850,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b1,16'hFF85,16'h8009,1'b0,16'h0000,1'b0,4'd7}, // R7 ldim
    '{16'h1AB1,16'h1234,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'hAB34,16'h8001,1'b0,16'h0000,1'b0,4'd7}, // R7 ldimh
    '{16'h123B,16'h0000,16'hC001,16'h0001,16'h8001,16'h1000,1'b1,16'h8002,16'h8019,1'b0,16'h0000,1'b0,4'd8}, // R8 lsl
    '{16'h123C,16'h0000,16'h0003,16'h0001,16'h8001,16'h1000,1'b1,16'h0001,16'h8009,1'b0,16'h0000,1'b0,4'd8}, // R8 lsr
    '{16'h123C,16'h0000,16'h8000,16'h0000,16'h8009,16'h1000,1'b1,16'h8000,16'h8011,1'b0,16'h0000,1'b0,4'd8}, // R8 count 0
    '{16'h123C,16'h0000,16'hFFFF,16'h0014,16'h8001,16'h1000,1'b1,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd8}, // R8 lsr 20
    '{16'h123D,16'h0000,16'h8001,16'h0001,16'h8001,16'h1000,1'b1,16'hC000,16'h8019,1'b0,16'h0000,1'b0,4'd8}, // R8 asr 1
    '{16'h123D,16'h0000,16'h8000,16'h0014,16'h8001,16'h1000,1'b1,16'hFFFF,16'h8019,1'b0,16'h0000,1'b0,4'd8}, // R8 asr 20
    '{16'h123D,16'h0000,16'h4000,16'h000F,16'h8001,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd8}, // R8 asr 15
    '{16'h18DF,16'h8180,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'h0081,16'h8009,1'b0,16'h0000,1'b0,4'd9}, // R9 right 8
    '{16'h13DF,16'h2001,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'h0008,16'h8009,1'b0,16'h0000,1'b0,4'd9}, // R9 left 3
    '{16'h10DF,16'h01FF,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'hFF00,16'h8019,1'b0,16'h0000,1'b0,4'd9}, // R9 left 8
    '{16'h19DF,16'h0001,16'h0000,16'h0000,16'h8001,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd9}, // R9 right 1
    '{16'h121F,16'h0000,16'h0001,16'h0000,16'h8001,16'h1000,1'b1,16'hFFFF,16'h8019,1'b0,16'h0000,1'b0,4'd3}, // R3 neg
    '{16'h121F,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b1,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd3}, // R3 neg zero
    '{16'h122F,16'h0000,16'hFFFF,16'h0000,16'h8009,16'h1000,1'b1,16'h0000,16'h800D,1'b0,16'h0000,1'b0,4'd4}, // R4 not
    '{16'h520F,16'h0000,16'hBEEF,16'h0000,16'h8001,16'h1000,1'b1,16'hBEEF,16'h8001,1'b0,16'h0000,1'b0,4'd2}, // R2 mov, index 5
    '{16'h003E,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8001,1'b1,16'h1006,1'b0,4'd10}, // R10 always
    '{16'h103E,16'h0000,16'h0000,16'h0000,16'h801D,16'h1000,1'b0,16'h0000,16'h801D,1'b0,16'h0000,1'b0,4'd10}, // R10 never
    '{16'h2FEE,16'h0000,16'h0000,16'h0000,16'h8005,16'h1000,1'b0,16'h0000,16'h8005,1'b1,16'h0FFC,1'b0,4'd10}, // R10 zero, back
    '{16'h3FEE,16'h0000,16'h0000,16'h0000,16'h8005,16'h1000,1'b0,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd10}, // R10 not zero
    '{16'h47FE,16'h0000,16'h0000,16'h0000,16'h8011,16'h1000,1'b0,16'h0000,16'h8011,1'b1,16'h10FE,1'b0,4'd10}, // R10 negative
    '{16'h57FE,16'h0000,16'h0000,16'h0000,16'h8011,16'h1000,1'b0,16'h0000,16'h8011,1'b0,16'h0000,1'b0,4'd10}, // R10 positive
    '{16'h601E,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b0,16'h0000,16'h8009,1'b1,16'h1002,1'b0,4'd10}, // R10 carry
    '{16'h701E,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8001,1'b1,16'h1002,1'b0,4'd10}, // R10 no carry
    '{16'h701E,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b0,16'h0000,16'h8009,1'b0,16'h0000,1'b0,4'd10}, // R10 no carry, C set
    '{16'h801E,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8001,1'b1,16'h1002,1'b0,4'd10}, // R10 greater
    '{16'h801E,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b0,16'h0000,16'h8009,1'b0,16'h0000,1'b0,4'd10}, // R10 greater, C
    '{16'h801E,16'h0000,16'h0000,16'h0000,16'h8005,16'h1000,1'b0,16'h0000,16'h8005,1'b0,16'h0000,1'b0,4'd10}, // R10 greater, Z
    '{16'h901E,16'h0000,16'h0000,16'h0000,16'h8009,16'h1000,1'b0,16'h0000,16'h8009,1'b1,16'h1002,1'b0,4'd10}, // R10 leq
    '{16'hA01E,16'h0000,16'h0000,16'h0000,16'h8001,16'h1000,1'b0,16'h0000,16'h8001,1'b0,16'h0000,1'b1,4'd11}, // R11 cond 10
    '{16'hF01E,16'h0000,16'h0000,16'h0000,16'h801D,16'h1000,1'b0,16'h0000,16'h801D,1'b0,16'h0000,1'b1,4'd11}, // R11 cond 15
    '{16'h724F,16'h0000,16'h3456,16'h0000,16'h8001,16'h1000,1'b1,16'h0FFE,16'h8001,1'b1,16'h3456,1'b0,4'd12}, // R12 call
    '{16'h1232,16'h0000,16'h0001,16'h0002,16'h801D,16'h1000,1'b0,16'h0000,16'h801D,1'b0,16'h0000,1'b0,4'd13}, // R13 memory load
    '{16'h125F,16'h0000,16'h0001,16'h0002,16'h801D,16'h1000,1'b0,16'h0000,16'h801D,1'b0,16'h0000,1'b0,4'd13}  // R13 swap
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] instr, pc, rd_dst, rd_a, rd_b, sr_in;
  logic        out_valid, wb_en, br_taken, illegal;
  logic [3:0]  wb_idx;
  logic [15:0] wb_data, sr_out, br_target;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  exu_core u_exu_core (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr), .pc (pc),
    .rd_dst (rd_dst), .rd_a (rd_a), .rd_b (rd_b), .sr_in (sr_in),
    .out_valid (out_valid), .wb_en (wb_en), .wb_idx (wb_idx), .wb_data (wb_data),
    .sr_out (sr_out), .br_taken (br_taken), .br_target (br_target), .illegal (illegal)
  );

  task automatic check_quiet(input string tag);
    checks++;
    if (out_valid || wb_en || br_taken || illegal) begin
      errors++;
      $display("FAIL %s: valid=%0b wb=%0b br=%0b ill=%0b, expected all 0",
               tag, out_valid, wb_en, br_taken, illegal);
    end
  endtask

  task automatic apply(input vec_t v);
    in_valid = 1'b1; instr = v.instr; rd_dst = v.dv; rd_a = v.av;
    rd_b = v.bv; sr_in = v.sr; pc = v.pc;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    bit ok;
    ok = out_valid && (wb_en == v.wbe) && (sr_out == v.sro) &&
         (br_taken == v.br) && (illegal == v.ill) &&
         (!v.wbe || (wb_data == v.wbd && wb_idx == v.instr[15:12])) &&
         (!v.br || br_target == v.tgt);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d vec %0d: got wb=%0b/%0d/%h sr=%h br=%0b/%h ill=%0b, expected wb=%0b/%0d/%h sr=%h br=%0b/%h ill=%0b",
               v.req, idx, wb_en, wb_idx, wb_data, sr_out, br_taken, br_target, illegal,
               v.wbe, v.instr[15:12], v.wbd, v.sro, v.br, v.tgt, v.ill);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; pc = '0;
    rd_dst = '0; rd_a = '0; rd_b = '0; sr_in = '0;
    repeat (3) @(negedge clk);
    check_quiet("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 idle after reset");

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check_vec(VECS[i], i);
    end

    // R13: system sub-opcode leaves nothing behind, seen on the next cycle
    apply('{16'h12FF,16'h0,16'h0,16'h0,16'h801D,16'h1000,1'b0,16'h0,16'h801D,1'b0,16'h0,1'b0,4'd13});
    @(negedge clk);
    check_vec('{16'h12FF,16'h0,16'h0,16'h0,16'h801D,16'h1000,1'b0,16'h0,16'h801D,1'b0,16'h0,1'b0,4'd13}, NV);

    // R1: valid drops one cycle after in_valid falls
    in_valid = 1'b0;
    @(negedge clk);
    check_quiet("R1 in_valid low");

    // R1: asynchronous reset clears a pending taken branch
    apply(VECS[33]);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_quiet("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset release");

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule